// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block sits after clock recovery and NRZI decoding. It takes one received line bit per strobe and turns the bit stream into a byte stream. It finds opening and closing flags and drops the zero bits that the transmitter inserted after runs of ones. It assembles data bytes with the least significant bit first and abandons reception when it sees a run of seven ones.

Flags are passed downstream as in-band markers. Every data byte whose value matches one of the three control codes is written after an escape byte. A consumer can therefore split frames from the byte stream alone.

Each write is a one-cycle strobe with its byte. The consumer signals that it has no room through a full input. That input is sampled on the bit strobe that completes a flag or byte. A refused write is dropped, and reception stops until the next flag. Frame check sequence verification, frame length limits and bit clock recovery belong to other blocks.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset no write is issued, and reception stays inactive until a flag is seen.
- R2: When the last eight strobed bits, oldest first, read 0,1,1,1,1,1,1,0 (value 0x7E with the newest bit as bit 0), the byte 0x7E is written, reception becomes active and the data bit count restarts. This applies whether reception was active or inactive.
- R3: While active, seven consecutive 1 bits (the last seven bits, checked with mask 0x7F) that do not complete a flag abort reception. The partial byte is discarded and nothing is written.
- R4: While inactive, every bit other than one completing a flag causes no write.
- R5: While active, a 0 bit that follows exactly five 1 bits (last six bits 111110) and does not complete a flag is discarded and does not count as data.
- R6: Data bits fill a byte from bit 0 upward. The first data bit after a flag becomes bit 0. After eight data bits the byte is written and the count restarts.
- R7: A completed byte equal to 0x7E, 0x7F or the escape code (default 0x1B) is written as two writes on consecutive cycles: the escape code first, then the byte.
- R8: If `sink_full` is high on the strobe that completes a flag or a byte, none of that event's writes are issued and reception becomes inactive.
- R9: The first write of an event appears on `out_vld` in the cycle after the strobe that completed it. Each write lasts exactly one cycle.
- R10: Cycles with `bit_vld` low shift nothing and change no state, whatever `bit_in` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new received bit |
| bit_in | input | 1 | Decoded line bit |
| sink_full | input | 1 | Consumer has no room; refuses the current event's writes |
| out_vld | output | 1 | One-cycle write strobe |
| out_byte | output | 8 | Byte written with `out_vld` |

## Verification
The bench builds the block with the escape code at its default of 0x1B. This places all three control-code collisions in a short table of data bytes, next to bytes that force zero insertion in the middle and at the end of a byte. Strobes are sent back to back and also with idle cycles while `bit_in` toggles. This exercises the consecutive escape and data writes against the two-entry skid, and confirms that idle cycles are ignored. Directed runs cover an abort after seven data bits, a refused flag and a refused data byte.

// File: rtl/hdrx_pkg.sv
package hdrx_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int STUFF_RUN = 5;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t FLAG_CODE   = 8'h7E;
  localparam byte_t ABORT_CODE  = 8'h7F;
  localparam byte_t ABORT_MASK  = 8'h7F;
  localparam byte_t ESC_DEFAULT = 8'h1B;
  localparam byte_t STUFF_MASK  = byte_t'((1 << (STUFF_RUN + 1)) - 1);
  localparam byte_t STUFF_PAT   = byte_t'(((1 << STUFF_RUN) - 1) << 1);

  typedef enum logic [2:0] {EV_NONE, EV_FLAG, EV_ABORT, EV_STUFF, EV_DATA} hdrx_ev_e;

  function automatic logic is_flag(input byte_t h);
    return h == FLAG_CODE;
  endfunction

  function automatic logic is_abort(input byte_t h);
    return (h & ABORT_MASK) == ABORT_CODE;
  endfunction

  function automatic logic is_stuffed(input byte_t h);
    return (h & STUFF_MASK) == STUFF_PAT;
  endfunction

  function automatic logic needs_escape(input byte_t b, input byte_t esc);
    return (b == FLAG_CODE) || (b == ABORT_CODE) || (b == esc);
  endfunction
endpackage

// File: rtl/hdrx_detect.sv
module hdrx_detect
  import hdrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_in,
  output hdrx_ev_e ev
);
  logic [BYTE_W-2:0] hist_q;
  byte_t             hist_n;

  assign hist_n = {hist_q, bit_in};

  // flag wins over abort and destuff
  always_comb begin
    if (!bit_vld)                ev = EV_NONE;
    else if (is_flag(hist_n))    ev = EV_FLAG;
    else if (is_abort(hist_n))   ev = EV_ABORT;
    else if (is_stuffed(hist_n)) ev = EV_STUFF;
    else                         ev = EV_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hist_q <= '0;
    else if (bit_vld) hist_q <= hist_n[BYTE_W-2:0];
  end
endmodule

// File: rtl/hdrx_assemble.sv
module hdrx_assemble
  import hdrx_pkg::*;
#(
  parameter byte_t ESC_CODE = ESC_DEFAULT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hdrx_ev_e ev,
  input  logic     bit_in,
  input  logic     sink_full,
  output logic [1:0] push_n,
  output byte_t    push_b0,
  output byte_t    push_b1
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] cur_q;
  byte_t             nxt_byte;
  logic              byte_done;

  assign nxt_byte  = {bit_in, cur_q};
  assign byte_done = (ev == EV_DATA) && active_q && (cnt_q == LAST_BIT);

  always_comb begin
    push_n  = 2'd0;
    push_b0 = FLAG_CODE;
    push_b1 = nxt_byte;
    if (ev == EV_FLAG && !sink_full) begin
      push_n = 2'd1;
    end else if (byte_done && !sink_full) begin
      if (needs_escape(nxt_byte, ESC_CODE)) begin
        push_n  = 2'd2;
        push_b0 = ESC_CODE;
      end else begin
        push_n  = 2'd1;
        push_b0 = nxt_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
    end else begin
      case (ev)
        EV_FLAG: begin
          active_q <= !sink_full;
          cnt_q    <= '0;
        end
        EV_ABORT: active_q <= 1'b0;
        EV_DATA: if (active_q) begin
          cur_q <= nxt_byte[BYTE_W-1:1];
          if (cnt_q == LAST_BIT) begin
            cnt_q <= '0;
            if (sink_full) active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ev == EV_NONE) |=> $stable(active_q) && $stable(cnt_q)); // R10
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ev == EV_ABORT) |=> !active_q); // R3
  AST_FLAG_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (ev == EV_FLAG && !sink_full) |=> active_q && cnt_q == '0); // R2
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ev != EV_NONE && sink_full) |-> push_n == 2'd0); // R8
  AST_INACTIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!active_q && ev != EV_FLAG) |-> push_n == 2'd0); // R4
endmodule

// File: rtl/hdrx_skid.sv
module hdrx_skid
  import hdrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] push_n,
  input  byte_t      push_b0,
  input  byte_t      push_b1,
  output logic       out_vld,
  output byte_t      out_byte
);
  logic [1:0] occ_q;
  byte_t      slot_q [2];
  logic       pop;
  logic [1:0] keep;
  logic [2:0] fill;
  logic       ovf;
  byte_t      s0_n, s1_n;

  assign pop  = (occ_q != 2'd0);
  assign keep = occ_q - {1'b0, pop};
  assign fill = {1'b0, keep} + {1'b0, push_n};
  assign ovf  = (fill > 3'd2);

  always_comb begin
    if (keep == 2'd0) begin
      s0_n = push_b0;
      s1_n = push_b1;
    end else begin
      s0_n = slot_q[1];
      s1_n = push_b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q     <= 2'd0;
      slot_q[0] <= '0;
      slot_q[1] <= '0;
    end else begin
      occ_q     <= ovf ? 2'd2 : fill[1:0];
      slot_q[0] <= s0_n;
      slot_q[1] <= s1_n;
    end
  end

  assign out_vld  = pop;
  assign out_byte = slot_q[0];

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !ovf); // R9
  AST_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (push_n == 2'd2) |=> out_vld ##1 out_vld); // R7
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdrx_pkg::*;
#(
  parameter byte_t ESC_CODE = ESC_DEFAULT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       sink_full,
  output logic       out_vld,
  output logic [7:0] out_byte
);
  hdrx_ev_e   ev;
  logic [1:0] push_n;
  byte_t      push_b0, push_b1;

  hdrx_detect u_detect (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .ev(ev)
  );

  hdrx_assemble #(.ESC_CODE(ESC_CODE)) u_assemble (
    .clk(clk), .rst_n(rst_n), .ev(ev), .bit_in(bit_in), .sink_full(sink_full),
    .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
  );

  hdrx_skid u_skid (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_b0(push_b0),
    .push_b1(push_b1), .out_vld(out_vld), .out_byte(out_byte)
  );

  AST_WRITE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_vld) |-> $past(bit_vld)); // R9
endmodule

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ESC  = 8'h1B;
  // {escape expected, data byte}
  localparam logic [8:0] VEC [0:11] = '{
    {1'b0, 8'h00}, {1'b0, 8'h01}, {1'b0, 8'hFF}, {1'b1, 8'h7E},
    {1'b1, 8'h7F}, {1'b1, 8'h1B}, {1'b0, 8'h3E}, {1'b0, 8'h1F},
    {1'b0, 8'hF8}, {1'b0, 8'hC8}, {1'b0, 8'h5A}, {1'b0, 8'h1C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic sink_full = 1'b0;
  logic out_vld;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  int capn = 0;
  int gap = 0;
  int ones_run = 0;
  logic [7:0] cap_b [0:255];
  time cap_t [0:255];
  time last_t = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .sink_full(sink_full), .out_vld(out_vld), .out_byte(out_byte)
  );

  always @(negedge clk) begin
    if (out_vld && capn < 256) begin
      cap_b[capn] = out_byte;
      cap_t[capn] = $time;
      capn = capn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_byte(input int idx, input logic [7:0] exp, input string req);
    if (idx < capn) chk(cap_b[idx] == exp, req, int'(cap_b[idx]), int'(exp));
    else            chk(1'b0, req, -1, int'(exp));
  endtask

  // starts and ends on a falling edge; idle cycles toggle bit_in
  task automatic send_bit(input logic b);
    bit_vld = 1'b1;
    bit_in  = b;
    last_t  = $time;
    @(negedge clk);
    bit_vld = 1'b0;
    bit_in  = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit(FLAG[i]);
    ones_run = 0;
  endtask

  task automatic send_data(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) begin
        ones_run++;
        if (ones_run == 5) begin
          send_bit(1'b0);
          ones_run = 0;
        end
      end else begin
        ones_run = 0;
      end
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    time tflag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 reset out_vld", int'(out_vld), 0);

    // R1 R4: bits before any flag write nothing
    send_data(8'h55);
    send_data(8'h12);
    settle();
    chk(capn == 0, "R4 inactive before flag", capn, 0);

    // table: flag, byte, flag under varying strobe gaps (R10)
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      logic esc;
      v    = VEC[i][7:0];
      esc  = VEC[i][8];
      gap  = i % 3;
      base = capn;
      send_flag();
      send_data(v);
      send_flag();
      tflag = last_t;
      settle();
      chk(capn - base == (esc ? 4 : 3), "R6 R10 write count", capn - base, esc ? 4 : 3);
      chk_byte(base, FLAG, "R2 opening flag");
      if (esc) begin
        chk_byte(base + 1, ESC, "R7 escape first");
        chk_byte(base + 2, v, "R6 R5 data byte");
        chk(cap_t[base + 2] == cap_t[base + 1] + CLK_PERIOD, "R7 consecutive",
            int'(cap_t[base + 2] - cap_t[base + 1]), CLK_PERIOD);
      end else begin
        chk_byte(base + 1, v, "R6 R5 data byte");
      end
      chk_byte(base + (esc ? 3 : 2), FLAG, "R2 closing flag");
      chk(cap_t[base + (esc ? 3 : 2)] == tflag + CLK_PERIOD, "R9 write timing",
          int'(cap_t[base + (esc ? 3 : 2)] - tflag), CLK_PERIOD);
    end
    gap = 0;

    // R3: abort after seven data bits, then data ignored until flag
    base = capn;
    send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_data(8'h3C);
    settle();
    chk(capn - base == 1, "R3 abort drops partial byte", capn - base, 1);
    send_flag();
    send_data(8'h42);
    send_flag();
    settle();
    chk(capn - base == 4, "R3 resume after abort", capn - base, 4);
    chk_byte(base + 2, 8'h42, "R3 resumed byte");

    // R8: refused flag leaves reception inactive
    base = capn;
    sink_full = 1'b1;
    send_flag();
    sink_full = 1'b0;
    send_data(8'h33);
    settle();
    chk(capn - base == 0, "R8 refused flag", capn - base, 0);

    // R8: refused data byte, following byte ignored
    base = capn;
    send_flag();
    sink_full = 1'b1;
    send_data(8'h44);
    sink_full = 1'b0;
    send_data(8'h55);
    settle();
    chk(capn - base == 1, "R8 refused byte", capn - base, 1);
    send_flag();
    settle();
    chk(capn - base == 2, "R8 flag after refusal", capn - base, 2);

    // R2: flags sharing a zero bit, back to back
    base = capn;
    send_flag();
    for (int i = 1; i < 8; i++) send_bit(FLAG[i]);
    settle();
    chk(capn - base == 2, "R2 shared-zero flags", capn - base, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule